// File: doc/BRIEF.md
# Load/Store Byte-Lane Unit

This unit connects the address and data side of an integer execute stage to a 32-bit, word-organised, byte-addressed data memory that accepts one access per cycle. From a base register value and a 12-bit signed offset it forms the effective byte address. It then presents a word-aligned address to the memory.

For stores, the unit copies the source operand across the byte lanes and raises only the byte enables that belong to the access. For loads, the memory word returns one cycle after the request. The unit selects the addressed byte, halfword or word from that word, using the registered low address bits and the registered access size, and widens the result to 32 bits with sign or zero fill.

Memory is little-endian: the lowest byte address holds the least significant byte. Accesses that are not naturally aligned are flagged and never reach the memory. Encodings that do not name a supported access are reported as illegal and also never reach the memory.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address is `base` plus `offset` sign-extended from bit 11 to 32 bits. On an issued request, `mem_addr` equals that address with bits 1:0 cleared.
- R2: A byte store (`funct3` = 0) drives a `mem_be` that is one-hot at lane `ea[1:0]`. Bit 0 of `mem_be` is the lowest byte address. `mem_wdata` carries `store_src[7:0]` in all four lanes.
- R3: A halfword store (`funct3` = 1) drives `mem_be` = 4'b0011 when `ea[1]` is 0 and 4'b1100 when it is 1. `mem_wdata` carries `store_src[15:0]` in both halves.
- R4: A word store (`funct3` = 2) drives `mem_be` = 4'b1111 and `mem_wdata` = `store_src`.
- R5: A byte load returns memory byte `ea`. With `funct3` = 0, bit 7 of that byte fills bits 31:8. With `funct3` = 4, bits 31:8 are zero.
- R6: A halfword load returns the bytes at `ea` (low) and `ea`+1 (high). With `funct3` = 1, bit 15 fills bits 31:16. With `funct3` = 5, bits 31:16 are zero.
- R7: A word load (`funct3` = 2) returns the four bytes from `ea` to `ea`+3, least significant first.
- R8: `load_valid` is high exactly in the cycle after an accepted load request (aligned or misaligned). `load_data` is zero whenever `load_valid` is low.
- R9: A halfword access with `ea[0]` = 1, or a word access with `ea[1:0]` != 0, raises `misaligned` and issues no memory request or write. A misaligned load still gives `load_valid` in the next cycle, with `load_data` = 0.
- R10: `illegal` is raised, and no memory request is issued, in three cases: both strobes are high together; a load uses `funct3` 3, 6 or 7; or a store uses `funct3` 3 to 7. An illegal load produces no `load_valid`.
- R11: While reset is held, `load_valid` and `load_data` are zero.
- R12: Without a request, `mem_req`, `mem_we`, `mem_be`, `misaligned` and `illegal` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_load | input | 1 | Load request strobe |
| req_store | input | 1 | Store request strobe |
| funct3 | input | 3 | Access size and signedness code |
| base | input | 32 | Base register value |
| offset | input | 12 | Signed address offset |
| store_src | input | 32 | Store source register value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Read word, valid the cycle after the request |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Extended load result |
| misaligned | output | 1 | Access not naturally aligned |
| illegal | output | 1 | Unsupported encoding or strobe combination |

## Verification
The bench first writes a known word through a store whose offset is negative, so that sign extension of the offset is exercised. Byte and halfword stores then patch single lanes, and the following loads show whether only the enabled lanes changed.

Loads are issued at every byte offset, with bytes whose top bit is set and bytes whose top bit is clear. Each is tried in the signed and the unsigned form, which separates lane selection errors from fill errors.

Misaligned halfword and word accesses are mixed in, and a later aligned load confirms that a misaligned store left memory untouched. Reserved codes and dual strobes check that no request and no result come out.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   localparam int unsigned LANE_BITS = 8;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFFS_W = 12
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFFS_W-1:0] offset,
   output logic [ADDR_W-1:0] ea
);
   localparam int unsigned EXT_W = ADDR_W - OFFS_W;

   logic [ADDR_W-1:0] offs_ext;

   generate
      if (EXT_W == 0) begin : g_noext
         assign offs_ext = offset;
      end else begin : g_ext
         assign offs_ext = {{EXT_W{offset[OFFS_W-1]}}, offset};
      end
   endgenerate

   assign ea = base + offs_ext;
endmodule

// File: rtl/lsu_access_decode.sv
module lsu_access_decode
   import lsu_lane_pkg::*;
(
   input  logic       req_load,
   input  logic       req_store,
   input  logic [2:0] funct3,
   input  logic [1:0] ea_lo,
   output acc_size_e  size,
   output logic       is_unsigned,
   output logic       illegal,
   output logic       misaligned,
   output logic       go
);
   logic any_req;
   logic both_req;
   logic load_code_ok;
   logic store_code_ok;
   logic align_bad;

   assign size        = acc_size_e'(funct3[1:0]);
   assign is_unsigned = funct3[2];
   assign any_req     = req_load | req_store;
   assign both_req    = req_load & req_store;

   always_comb begin
      unique case (funct3)
         3'd0, 3'd1, 3'd2, 3'd4, 3'd5: load_code_ok = 1'b1;
         default:                      load_code_ok = 1'b0;
      endcase
      store_code_ok = (funct3[2] == 1'b0) && (funct3[1:0] != 2'd3);
   end

   always_comb begin
      unique case (size)
         SZ_HALF: align_bad = ea_lo[0];
         SZ_WORD: align_bad = (ea_lo != 2'd0);
         default: align_bad = 1'b0;
      endcase
   end

   assign illegal    = both_req
                     | (req_load  & ~req_store & ~load_code_ok)
                     | (req_store & ~req_load  & ~store_code_ok);
   assign misaligned = any_req & ~illegal & align_bad;
   assign go         = any_req & ~illegal & ~align_bad;
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
   import lsu_lane_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  acc_size_e                 size,
   input  logic [1:0]                lane_off,
   input  logic [DATA_W-1:0]         src,
   output logic [DATA_W/LANE_BITS-1:0] be,
   output logic [DATA_W-1:0]         wdata
);
   localparam int unsigned LANES = DATA_W / LANE_BITS;

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         localparam logic [1:0] LANE_ID = 2'(k);
         always_comb begin
            unique case (size)
               SZ_BYTE: begin
                  wdata[k*LANE_BITS +: LANE_BITS] = src[LANE_BITS-1:0];
                  be[k] = (lane_off == LANE_ID);
               end
               SZ_HALF: begin
                  wdata[k*LANE_BITS +: LANE_BITS] = src[(k%2)*LANE_BITS +: LANE_BITS];
                  be[k] = (lane_off[1] == LANE_ID[1]);
               end
               default: begin
                  wdata[k*LANE_BITS +: LANE_BITS] = src[k*LANE_BITS +: LANE_BITS];
                  be[k] = 1'b1;
               end
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
   import lsu_lane_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  acc_size_e         size,
   input  logic              is_unsigned,
   input  logic [1:0]        lane_off,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] result
);
   localparam int unsigned LANES  = DATA_W / LANE_BITS;
   localparam int unsigned HALF_W = 2 * LANE_BITS;
   localparam int unsigned HALVES = DATA_W / HALF_W;

   logic [LANE_BITS-1:0] lane_v [LANES];
   logic [HALF_W-1:0]    half_v [HALVES];
   logic [LANE_BITS-1:0] sel_b;
   logic [HALF_W-1:0]    sel_h;

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_byte
         assign lane_v[k] = rdata[k*LANE_BITS +: LANE_BITS];
      end
      for (genvar h = 0; h < HALVES; h++) begin : g_half
         assign half_v[h] = rdata[h*HALF_W +: HALF_W];
      end
   endgenerate

   assign sel_b = lane_v[lane_off];
   assign sel_h = half_v[lane_off[1]];

   always_comb begin
      unique case (size)
         SZ_BYTE: result = {{(DATA_W-LANE_BITS){~is_unsigned & sel_b[LANE_BITS-1]}}, sel_b};
         SZ_HALF: result = {{(DATA_W-HALF_W){~is_unsigned & sel_h[HALF_W-1]}}, sel_h};
         default: result = rdata;
      endcase
   end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
   import lsu_lane_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFFS_W = 12,
   parameter int unsigned DATA_W = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_load,
   input  logic                          req_store,
   input  logic [2:0]                    funct3,
   input  logic [ADDR_W-1:0]             base,
   input  logic [OFFS_W-1:0]             offset,
   input  logic [DATA_W-1:0]             store_src,
   output logic                          mem_req,
   output logic                          mem_we,
   output logic [ADDR_W-1:0]             mem_addr,
   output logic [DATA_W/LANE_BITS-1:0]   mem_be,
   output logic [DATA_W-1:0]             mem_wdata,
   input  logic [DATA_W-1:0]             mem_rdata,
   output logic                          load_valid,
   output logic [DATA_W-1:0]             load_data,
   output logic                          misaligned,
   output logic                          illegal
);
   localparam int unsigned LANES = DATA_W / LANE_BITS;

   generate
      if (DATA_W != 32 || ADDR_W < 2 || OFFS_W > ADDR_W || OFFS_W < 2) begin : g_bad_cfg
         $error("lsu_lane_unit: unsupported width configuration");
      end
   endgenerate

   logic [ADDR_W-1:0] ea;
   acc_size_e         size;
   logic              is_uns;
   logic              go;
   logic [LANES-1:0]  st_be;
   logic [DATA_W-1:0] st_data;
   logic [DATA_W-1:0] ld_ext;

   logic              vld_q;
   logic              zero_q;
   acc_size_e         size_q;
   logic              uns_q;
   logic [1:0]        off_q;

   lsu_addr_gen #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_agen (
      .base   (base),
      .offset (offset),
      .ea     (ea)
   );

   lsu_access_decode u_dec (
      .req_load    (req_load),
      .req_store   (req_store),
      .funct3      (funct3),
      .ea_lo       (ea[1:0]),
      .size        (size),
      .is_unsigned (is_uns),
      .illegal     (illegal),
      .misaligned  (misaligned),
      .go          (go)
   );

   lsu_store_steer #(.DATA_W(DATA_W)) u_st (
      .size     (size),
      .lane_off (ea[1:0]),
      .src      (store_src),
      .be       (st_be),
      .wdata    (st_data)
   );

   assign mem_req   = go;
   assign mem_we    = go & req_store;
   assign mem_addr  = {ea[ADDR_W-1:2], 2'b00};
   assign mem_be    = mem_we ? st_be : '0;
   assign mem_wdata = st_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         zero_q <= 1'b0;
         size_q <= SZ_WORD;
         uns_q  <= 1'b0;
         off_q  <= 2'd0;
      end else begin
         vld_q  <= req_load & ~illegal;
         zero_q <= req_load & misaligned;
         if (req_load) begin
            size_q <= size;
            uns_q  <= is_uns;
            off_q  <= ea[1:0];
         end
      end
   end

   lsu_load_align #(.DATA_W(DATA_W)) u_ld (
      .size        (size_q),
      .is_unsigned (uns_q),
      .lane_off    (off_q),
      .rdata       (mem_rdata),
      .result      (ld_ext)
   );

   assign load_valid = vld_q;
   assign load_data  = (vld_q && !zero_q) ? ld_ext : '0;

   assert_no_access_misaligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
      misaligned |-> (!mem_req && !mem_we));
   assert_misaligned_load_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_load && misaligned) |=> (load_valid && load_data == '0));
   assert_no_access_illegal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !mem_req);
   assert_illegal_no_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal && !req_store) |=> !load_valid);
   assert_result_next_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_load && mem_req) |=> load_valid);
   assert_idle_data_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !load_valid |-> (load_data == '0));
   assert_byte_single_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && funct3 == 3'd0) |-> ($countones(mem_be) == 1));
   assert_half_two_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && funct3 == 3'd1) |-> ($countones(mem_be) == 2));
   assert_word_all_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && funct3 == 3'd2) |-> (mem_be == 4'hF));
   assert_quiet_no_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_load && !req_store) |-> (!mem_req && !illegal && !misaligned));
endmodule

// File: tb/sim_lsu_lane_unit.sv
`timescale 1ns/1ps
module sim_lsu_lane_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_load = 1'b0, req_store = 1'b0;
   logic [2:0]  funct3 = 3'd0;
   logic [31:0] base = '0;
   logic [11:0] offset = '0;
   logic [31:0] store_src = '0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata, load_data;
   logic [3:0]  mem_be;
   logic [31:0] mem_rdata = '0;
   logic        load_valid, misaligned, illegal;

   int unsigned n_tests = 0;
   int unsigned n_fail  = 0;
   bit          started = 1'b0;
   bit          due     = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] mem [16];
   logic [7:0]  rb  [64];

   always #2.5 clk = ~clk;

   lsu_lane_unit u0 (
      .clk(clk), .rst_n(rst_n), .req_load(req_load), .req_store(req_store),
      .funct3(funct3), .base(base), .offset(offset), .store_src(store_src),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .load_valid(load_valid),
      .load_data(load_data), .misaligned(misaligned), .illegal(illegal)
   );

   // synchronous memory model: one-cycle read latency, byte-enabled writes
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            for (int k = 0; k < 4; k++)
               if (mem_be[k]) mem[mem_addr[5:2]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
         end else begin
            mem_rdata <= mem[mem_addr[5:2]];
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      req_load = 1'b0; req_store = 1'b0; due = 1'b0;
      #1;
      chk("R12 quiet mem_req", {31'd0, mem_req}, 32'd0);
      chk("R12 quiet flags", {30'd0, illegal, misaligned}, 32'd0);
   endtask

   task automatic op(bit ld, bit st, logic [2:0] f3, logic [31:0] b,
                     logic [11:0] off, logic [31:0] src, string tag);
      logic [31:0] ea, ex_wd, ex_ld;
      logic [3:0]  ex_be;
      logic [1:0]  sz;
      bit ill, mis, rq, we;
      @(negedge clk);
      req_load = ld; req_store = st; funct3 = f3; base = b; offset = off; store_src = src;
      ea  = b + {{20{off[11]}}, off};
      sz  = f3[1:0];
      ill = (ld && st) || (ld && !st && !(f3 inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd5}))
            || (st && !ld && f3 > 3'd2);
      mis = !ill && ((sz == 2'd1 && ea[0]) || (sz == 2'd2 && ea[1:0] != 2'd0));
      rq  = !ill && !mis;
      we  = rq && st;
      ex_be = 4'h0;
      ex_wd = src;
      if (we) begin
         if (sz == 2'd0) begin ex_be = 4'b0001 << ea[1:0]; ex_wd = {4{src[7:0]}}; end
         else if (sz == 2'd1) begin ex_be = ea[1] ? 4'b1100 : 4'b0011; ex_wd = {2{src[15:0]}}; end
         else ex_be = 4'hF;
      end
      due = ld && !ill;
      #1;
      chk({tag, " R10 illegal"}, {31'd0, illegal}, {31'd0, ill});
      chk({tag, " R9 misaligned"}, {31'd0, misaligned}, {31'd0, mis});
      chk({tag, " R9/R10 mem_req"}, {31'd0, mem_req}, {31'd0, rq});
      chk({tag, " mem_we"}, {31'd0, mem_we}, {31'd0, we});
      chk({tag, " R2/R3/R4 mem_be"}, {28'd0, mem_be}, {28'd0, ex_be});
      if (rq) chk({tag, " R1 mem_addr"}, mem_addr, {ea[31:2], 2'b00});
      if (we) begin
         chk({tag, " R2/R3/R4 mem_wdata"}, mem_wdata, ex_wd);
         for (int k = 0; k < 4; k++)
            if (ex_be[k]) rb[{ea[5:2], 2'(k)}] = ex_wd[k*8 +: 8];
      end
      if (ld && !ill) begin
         if (mis) ex_ld = '0;
         else if (sz == 2'd0) ex_ld = {{24{~f3[2] & rb[ea[5:0]][7]}}, rb[ea[5:0]]};
         else if (sz == 2'd1) ex_ld = {{16{~f3[2] & rb[ea[5:0]+6'd1][7]}},
                                       rb[ea[5:0]+6'd1], rb[ea[5:0]]};
         else ex_ld = {rb[ea[5:0]+6'd3], rb[ea[5:0]+6'd2], rb[ea[5:0]+6'd1], rb[ea[5:0]]};
         exp_q.push_back(ex_ld);
         tag_q.push_back(tag);
      end
   endtask

   // monitor: compares results against the scoreboard one clock after each request
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (started) begin
            chk("R8 load_valid timing", {31'd0, load_valid}, {31'd0, due});
            if (load_valid) begin
               if (exp_q.size() == 0) begin
                  chk("R8 unexpected result", 32'd1, 32'd0);
               end else begin
                  logic [31:0] e;
                  string t;
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  chk({t, " load_data"}, load_data, e);
               end
            end else begin
               chk("R8 idle load_data", load_data, 32'd0);
            end
         end
      end
   end

   initial begin
      #(5.0 * 20000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = '0;
      for (int i = 0; i < 64; i++) rb[i] = '0;
      repeat (3) @(negedge clk);
      chk("R11 reset load_valid", {31'd0, load_valid}, 32'd0);
      chk("R11 reset load_data", load_data, 32'd0);
      rst_n = 1'b1;
      started = 1'b1;
      idle();
      // R1: negative offset, word store at 0x10
      op(0, 1, 3'd2, 32'h20, 12'hFF0, 32'hA1B2_C3D4, "R4 sw 0x10");
      op(0, 1, 3'd2, 32'h20, 12'h004, 32'h7F80_0155, "R4 sw 0x24");
      // R2, R3: partial stores
      op(0, 1, 3'd0, 32'h20, 12'h001, 32'hFFFF_FF9C, "R2 sb 0x21");
      op(0, 1, 3'd0, 32'h20, 12'h003, 32'h0000_0011, "R2 sb 0x23");
      op(0, 1, 3'd1, 32'h20, 12'h002, 32'h1234_8001, "R3 sh 0x22");
      op(0, 1, 3'd1, 32'h30, 12'hFFC, 32'h0000_7E5A, "R3 sh 0x2C");
      // R5: byte loads at every lane, signed and unsigned
      for (int k = 0; k < 4; k++) begin
         op(1, 0, 3'd0, 32'h10, 12'(k), '0, "R5 lb");
         op(1, 0, 3'd4, 32'h10, 12'(k), '0, "R5 lbu");
      end
      op(1, 0, 3'd0, 32'h24, 12'h001, '0, "R5 lb pos");
      op(1, 0, 3'd0, 32'h21, 12'h000, '0, "R5 lb patched");
      // R6: halfword loads, both halves, signed and unsigned
      op(1, 0, 3'd1, 32'h10, 12'h000, '0, "R6 lh lo");
      op(1, 0, 3'd1, 32'h10, 12'h002, '0, "R6 lh hi");
      op(1, 0, 3'd5, 32'h10, 12'h002, '0, "R6 lhu hi");
      op(1, 0, 3'd1, 32'h24, 12'h002, '0, "R6 lh pos");
      op(1, 0, 3'd5, 32'h40, 12'hFE2, '0, "R6 lhu 0x22");
      // R7: word loads
      op(1, 0, 3'd2, 32'h10, 12'h000, '0, "R7 lw 0x10");
      op(1, 0, 3'd2, 32'h20, 12'h000, '0, "R7 lw 0x20");
      op(1, 0, 3'd2, 32'h2C, 12'h000, '0, "R7 lw 0x2C");
      // R9: misaligned accesses
      op(1, 0, 3'd1, 32'h10, 12'h001, '0, "R9 lh mis");
      op(1, 0, 3'd2, 32'h10, 12'h002, '0, "R9 lw mis");
      op(1, 0, 3'd5, 32'h13, 12'h000, '0, "R9 lhu mis");
      op(0, 1, 3'd1, 32'h13, 12'h000, 32'hDEAD_BEEF, "R9 sh mis");
      op(0, 1, 3'd2, 32'h11, 12'h000, 32'hDEAD_BEEF, "R9 sw mis");
      op(1, 0, 3'd2, 32'h10, 12'h000, '0, "R9 lw after mis stores");
      // R10: reserved codes and dual strobes
      op(1, 0, 3'd3, 32'h10, 12'h000, '0, "R10 ld f3=3");
      op(1, 0, 3'd6, 32'h10, 12'h000, '0, "R10 ld f3=6");
      op(1, 0, 3'd7, 32'h10, 12'h000, '0, "R10 ld f3=7");
      op(0, 1, 3'd4, 32'h10, 12'h000, 32'h5555_5555, "R10 st f3=4");
      op(0, 1, 3'd3, 32'h10, 12'h000, 32'h5555_5555, "R10 st f3=3");
      op(1, 1, 3'd2, 32'h10, 12'h000, 32'h5555_5555, "R10 both strobes");
      op(1, 0, 3'd2, 32'h10, 12'h000, '0, "R10 lw after illegal stores");
      idle();
      idle();
      chk("R8 scoreboard drained", exp_q.size(), 32'd0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule